// File: doc/BRIEF.md
# Legacy Virtual Interrupt Wire Message Generator

This block sits in a link endpoint. It turns the level of an internal interrupt cause into in-band messages that raise and lower one virtual legacy interrupt wire upstream. Several cause bits are ORed into one wire level. The wire is gated by an interrupt-disable control bit and by a fixed pin selection that names one of four wires, A to D, or none.

A message goes out only when the wire changes level. A rising edge produces an assert message, and a falling edge produces a deassert message. Each message leaves as an 8-bit message code on a valid/ready request port. A later stage wraps the code into a packet. When the disable bit is set while the wire is up, the wire drops and a deassert is sent. When the bit is cleared while a cause is still pending, the wire rises again.

The block also registers an interrupt-status bit for configuration readback. That bit follows the pending causes whatever the disable bit says.

Top module: `vintx_msg_gen`

## Requirements
- R1: After synchronous active-low reset, `msg_valid_o` and `int_status_o` are 0.
- R2: When the wire goes from low to high, the block presents code 20h + (pin − 1) on `msg_code_o`, where pin encoding 1, 2, 3, 4 selects wire A, B, C, D. With the message slot free, `msg_valid_o` rises on the second rising clock edge after the cause input changes.
- R3: When the wire goes from high to low, the block presents code 24h + (pin − 1), with the same latency.
- R4: Setting more cause bits while the wire is already high produces no further message.
- R5: A pin selection of 0 (no pin), or any value from 5 to 7, produces no message at all.
- R6: While disable is 1, no new assert message is issued. If the wire is high when disable becomes 1, a deassert message is issued.
- R7: When disable returns to 0 while any cause bit is still set, an assert message is issued.
- R8: `int_status_o` equals the OR of the cause bits one clock earlier, whatever the disable value.
- R9: While `msg_valid_o` is 1 and `msg_ready_i` is 0, `msg_valid_o` and `msg_code_o` hold.
- R10: While a message waits, at most one opposite transition is queued. A pair of transitions that cancel each other is dropped. Accepted messages always alternate between assert and deassert, starting with an assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cause_i | input | N_CAUSES | Level-sensitive interrupt cause bits |
| int_disable_i | input | 1 | Interrupt-disable control bit |
| pin_sel_i | input | 3 | Static pin selection: 0 none, 1..4 wire A..D |
| msg_valid_o | output | 1 | Message request valid |
| msg_ready_i | input | 1 | Downstream accepts the message |
| msg_code_o | output | 8 | Message code of the request |
| int_status_o | output | 1 | Interrupt-status readback bit |

## Verification
The bench builds the block with the default of four cause bits. It sweeps all eight pin-selection values, applying a reset before each one. For every pin, each cause bit raises the wire in turn, so both code ranges are checked for every wire, and the unused encodings are shown to stay silent. With these small widths the bench can also step through the disable sequences (drop on disable, rise on re-enable) and the queued cancel pairs. In each case it predicts the next message code from the pin value alone.

// File: rtl/vintx_pkg.sv
// Package: shared constants and helpers for the virtual interrupt wire
// message generator. Assumes codes are eight bits and the pin field is
// three bits wide.
package vintx_pkg;
    localparam int PIN_W  = 3;
    localparam int CODE_W = 8;
    // Upper five bits shared by every wire message code.
    localparam logic [4:0] CODE_HI = 5'b00100;

    // True when the pin selection names one of the four wires.
    function automatic logic pin_is_wire(input logic [PIN_W-1:0] pin);
        return (pin >= 3'd1) && (pin <= 3'd4);
    endfunction
endpackage

// File: rtl/vintx_level_gen.sv
// Module: vintx_level_gen
// Computes the registered virtual wire level (OR of causes, gated by the
// disable bit and a valid pin) and the registered status bit, which
// ignores the disable bit. Assumes pin selection is static outside reset.
module vintx_level_gen
    import vintx_pkg::*;
#(
    parameter int N_CAUSES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CAUSES-1:0]  cause_i,
    input  logic                 int_disable_i,
    input  logic [PIN_W-1:0]     pin_sel_i,
    output logic                 level_o,
    output logic                 status_o
);
    logic any_cause;
    logic level_d;

    // Aggregate all cause bits.
    assign any_cause = |cause_i;

    // Wire is high only with a cause, no disable and a real pin.
    always_comb begin
        level_d = any_cause && !int_disable_i && pin_is_wire(pin_sel_i);
    end

    // Register level and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o  <= 1'b0;
            status_o <= 1'b0;
        end else begin
            level_o  <= level_d;
            status_o <= any_cause;
        end
    end

    AST_LEVEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        level_o |-> !$past(int_disable_i)); // R6
    AST_STATUS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        status_o == $past(|cause_i)); // R8
endmodule

// File: rtl/vintx_code_sel.sv
// Module: vintx_code_sel
// Combinational message code selection: assert codes 20h..23h and
// deassert codes 24h..27h, low two bits from the wire index.
// Assumes the pin value is a valid wire when the code is used.
module vintx_code_sel
    import vintx_pkg::*;
(
    input  logic [PIN_W-1:0]  pin_sel_i,
    input  logic              raise_i,
    output logic [CODE_W-1:0] code_o
);
    logic [PIN_W-1:0] wire_idx;

    // Build the code from direction and wire index.
    always_comb begin
        wire_idx = pin_sel_i - 3'd1;
        code_o   = {CODE_HI, !raise_i, wire_idx[1:0]};
    end
endmodule

// File: rtl/vintx_msg_slot.sv
// Module: vintx_msg_slot
// One-entry message register. It tracks the level the upstream side will
// see after all issued messages, and loads a new message whenever the
// wire level differs from that and the slot is free. This merges
// cancelling transitions and forces alternation.
module vintx_msg_slot
    import vintx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              valid_o,
    input  logic              ready_i,
    output logic [CODE_W-1:0] code_o,
    output logic              raise_o
);
    logic announced_q;
    logic slot_free;
    logic load;
    logic seen_q;
    logic last_raise_q;

    // Decide whether a new message enters the slot this cycle.
    always_comb begin
        slot_free = !valid_o || ready_i;
        load      = slot_free && (level_i != announced_q);
    end

    // Slot register and announced-level tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o     <= 1'b0;
            code_o      <= '0;
            raise_o     <= 1'b0;
            announced_q <= 1'b0;
        end else if (load) begin
            valid_o     <= 1'b1;
            code_o      <= code_i;
            raise_o     <= level_i;
            announced_q <= level_i;
        end else if (ready_i) begin
            valid_o     <= 1'b0;
        end
    end

    // Record the direction of the last accepted message for checking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q       <= 1'b0;
            last_raise_q <= 1'b0;
        end else if (valid_o && ready_i) begin
            seen_q       <= 1'b1;
            last_raise_q <= raise_o;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(code_o))); // R9
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && seen_q) |-> (raise_o != last_raise_q)); // R10
    AST_FIRST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !seen_q) |-> raise_o); // R10
endmodule

// File: rtl/vintx_msg_gen.sv
// Module: vintx_msg_gen (top)
// Virtual legacy interrupt wire message generator. Turns cause levels into
// assert/deassert message codes on a valid/ready port and provides the
// status readback bit. Assumes pin_sel_i only changes during reset.
module vintx_msg_gen
    import vintx_pkg::*;
#(
    parameter int N_CAUSES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_CAUSES-1:0] cause_i,
    input  logic                int_disable_i,
    input  logic [2:0]          pin_sel_i,
    output logic                msg_valid_o,
    input  logic                msg_ready_i,
    output logic [7:0]          msg_code_o,
    output logic                int_status_o
);
    logic              level;
    logic [CODE_W-1:0] next_code;
    logic              slot_raise;

    vintx_level_gen #(.N_CAUSES(N_CAUSES)) level_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cause_i      (cause_i),
        .int_disable_i(int_disable_i),
        .pin_sel_i    (pin_sel_i),
        .level_o      (level),
        .status_o     (int_status_o)
    );

    vintx_code_sel code_i (
        .pin_sel_i(pin_sel_i),
        .raise_i  (level),
        .code_o   (next_code)
    );

    vintx_msg_slot slot_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(level),
        .code_i (next_code),
        .valid_o(msg_valid_o),
        .ready_i(msg_ready_i),
        .code_o (msg_code_o),
        .raise_o(slot_raise)
    );

    AST_NO_PIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_is_wire(pin_sel_i) |-> !msg_valid_o); // R5
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> (msg_code_o[7:3] == CODE_HI
                         && {1'b0, msg_code_o[1:0]} == pin_sel_i - 3'd1
                         && msg_code_o[2] == !slot_raise)); // R2 R3
    AST_ASSERT_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_code_o[2] && !$past(msg_valid_o && !msg_ready_i))
            |-> $past(level)); // R6
endmodule

// File: tb/vintx_msg_gen_tb_top.sv
module vintx_msg_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cause = '0;
    logic       dis = 1'b0;
    logic [2:0] pin = '0;
    logic       valid;
    logic       ready = 1'b0;
    logic [7:0] code;
    logic       status;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    vintx_msg_gen #(.N_CAUSES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cause_i(cause), .int_disable_i(dis),
        .pin_sel_i(pin), .msg_valid_o(valid), .msg_ready_i(ready),
        .msg_code_o(code), .int_status_o(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    task automatic accept();
        ready = 1'b1; @(posedge clk); @(negedge clk); ready = 1'b0;
    endtask

    // Expect a message with code when the pin is a wire, else nothing.
    task automatic expect_msg(input bit wire_ok, input bit raise, input string req);
        int exp_code;
        exp_code = (raise ? 32'h20 : 32'h24) + int'(pin) - 1;
        if (wire_ok) chk(valid && code == exp_code[7:0], req, {valid, code}, {1'b1, exp_code[7:0]});
        else chk(!valid, req, valid, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hang expected=done");
            finish_run();
        end
    end

    initial begin
        for (int p = 0; p < 8; p++) begin
            bit w;
            w = (p >= 1 && p <= 4);
            @(negedge clk);
            rst_n = 0; pin = 3'(p); cause = 0; dis = 0; ready = 0;
            @(posedge clk); @(posedge clk); @(negedge clk);
            rst_n = 1;
            chk(!valid && !status, "R1", {valid, status}, 0);
            // Per-cause assert, extra cause, deassert sweep.
            for (int k = 0; k < 4; k++) begin
                cause = 4'(1 << k); step();
                expect_msg(w, 1, w ? "R2" : "R5");
                chk(status, "R8", status, 1);
                accept();
                cause = cause | 4'(1 << ((k + 1) % 4)); step();
                chk(!valid, "R4", valid, 0);
                cause = 0; step();
                expect_msg(w, 0, w ? "R3" : "R5");
                chk(!status, "R8", status, 0);
                accept();
            end
            // Disable while wire active, cause while disabled, re-enable.
            cause = 4'b0001; step(); expect_msg(w, 1, "R2"); accept();
            dis = 1; step();
            expect_msg(w, 0, "R6");
            chk(status, "R8", status, 1);
            accept();
            cause = 4'b0011; step();
            chk(!valid, "R6", valid, 0);
            dis = 0; step();
            expect_msg(w, 1, "R7"); accept();
            cause = 0; step(); expect_msg(w, 0, "R3"); accept();
            // Queued transitions while ready is low.
            cause = 4'b0100; step(); expect_msg(w, 1, "R2");
            cause = 0; step(); cause = 4'b0100; step();
            expect_msg(w, 1, "R9");
            accept();
            chk(!valid, "R10", valid, 0);
            cause = 0; step(); expect_msg(w, 0, "R3");
            cause = 4'b1000; step();
            expect_msg(w, 0, "R9");
            accept();
            expect_msg(w, 1, "R10");
            cause = 0; step();
            accept();
            expect_msg(w, 0, "R10");
            accept();
            chk(!valid, "R10", valid, 0);
        end
        done = 1;
        finish_run();
    end
endmodule